// File: doc/BRIEF.md
# Multithreaded Direct-Mapped Branch Target Buffer

This block holds predicted branch targets for a fetch stage that serves several hardware threads. Each entry is found directly from a fetch address. The requesting thread number is folded into the upper index bits, so that the same code run by different threads tends to land in different slots. The entry also keeps the thread number, the upper address bits used as a tag, and the target.

A lookup presents a fetch PC and a thread number and gets back, in the same cycle, a hit flag and the predicted target. The target is forced to zero on a miss. An update writes a PC, a thread number and a target into the slot that the PC and thread select. A synchronous reset empties the whole buffer in one cycle. The entry count, tag width, instruction alignment shift, thread count and address and target widths are parameters. The entry count and the thread count must be powers of two, and elaboration stops otherwise.

The block has no state machine. Its only sequential state is one valid flag per entry plus the entry payload. The flags have two values, empty (cleared by reset) and filled (set by an update). No other transitions exist.

Top module: `btb_mt`

## Requirements
- R1: After reset, every lookup misses (`lk_hit` = 0) and `lk_target` is zero.
- R2: The slot index is ((PC >> INST_SHIFT) XOR (tid << (log2(ENTRIES) − log2(THREADS)))) modulo ENTRIES. With the defaults (INST_SHIFT=2, ENTRIES=16, THREADS=4), this is PC[5:2] XOR {tid,2'b00}. Equal PCs from different threads therefore use different slots.
- R3: The tag is the TAG_W bits of PC starting at bit INST_SHIFT+log2(ENTRIES), which is PC[13:6] with the defaults. A lookup whose tag differs from the stored tag misses.
- R4: A lookup whose thread number differs from the one stored in the selected slot misses, even when the tag matches.
- R5: On a miss, `lk_hit` is 0 and `lk_target` is all zeros.
- R6: An update overwrites the selected slot unconditionally, whatever it held before. It sets the valid flag and stores the tag, the target and the thread number. Lookups see the new contents from the next clock edge on, and an entry that is replaced no longer hits.
- R7: A lookup made in the same cycle as an update to the same slot returns the slot's previous contents.
- R8: A reset empties all entries at one clock edge. An update presented in the same cycle as reset is discarded.
- R9: PC bits below INST_SHIFT, and PC bits above the tag field, do not affect the lookup result.
- R10: A stored target of zero is returned with `lk_hit` = 1, so it can be told apart from a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; empties every entry |
| lk_pc | input | PC_W | Fetch PC for lookup |
| lk_tid | input | TID_W | Thread number for lookup |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_target | output | TGT_W | Predicted target; zero on a miss |
| up_en | input | 1 | Write the update fields at the next edge |
| up_pc | input | PC_W | PC of the branch being recorded |
| up_tid | input | TID_W | Thread number of the branch being recorded |
| up_target | input | TGT_W | Target to record |

## Verification
A wrong valid flag, tag, thread number or target in a slot shows on the ports the first time a lookup selects that slot. The read path is combinational, so the fault appears in the same cycle as that lookup. It shows either as a hit where a miss is due, or as a wrong or non-zero target. Because of this, the stimulus steers lookups to slots whose state was just changed, from the cycle of the change onward. It covers writes, replacements, slots shared between threads and reset. It also checks the cycle of each update, when the old contents must still be visible.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Floor of log2 for positive values; 0 for values of 1 or less.
    function automatic int flog2(input int value);
        int r;
        r = 0;
        for (int v = value; v > 1; v = v >> 1) begin
            r = r + 1;
        end
        return r;
    endfunction

    function automatic bit is_pow2(input int value);
        return (value > 0) && ((value & (value - 1)) == 0);
    endfunction

endpackage

// File: rtl/btb_hash.sv
// Turns a PC and a thread number into a slot index and a tag.
module btb_hash #(
    parameter int PC_W       = 32,
    parameter int IDX_W      = 4,
    parameter int TAG_W      = 8,
    parameter int TID_W      = 2,
    parameter int INST_SHIFT = 2,
    parameter int TID_SHIFT  = 2
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [TID_W-1:0] tid,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);

    localparam int TAG_SHIFT = INST_SHIFT + IDX_W;
    localparam int WIDE_W    = IDX_W + TID_W;

    logic [PC_W-1:0]   pc_word;
    logic [PC_W-1:0]   pc_tag;
    logic [WIDE_W-1:0] tid_wide;

    always_comb begin
        pc_word  = pc >> INST_SHIFT;
        pc_tag   = pc >> TAG_SHIFT;
        tid_wide = {{IDX_W{1'b0}}, tid} << TID_SHIFT;
        idx      = pc_word[IDX_W-1:0] ^ tid_wide[IDX_W-1:0];
        tag      = pc_tag[TAG_W-1:0];
    end

endmodule

// File: rtl/btb_store.sv
// Entry storage: a valid-flag vector with reset, plus an unreset payload array.
module btb_store #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 8,
    parameter int TID_W   = 2,
    parameter int TGT_W   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TID_W-1:0] wr_tid,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TID_W-1:0] rd_tid,
    output logic [TGT_W-1:0] rd_tgt
);

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [TID_W-1:0]   tid_q [ENTRIES];
    logic [TGT_W-1:0]   tgt_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !rst) begin
            tag_q[wr_idx] <= wr_tag;
            tid_q[wr_idx] <= wr_tid;
            tgt_q[wr_idx] <= wr_tgt;
        end
    end

    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_tid   = tid_q[rd_idx];
        rd_tgt   = tgt_q[rd_idx];
    end

endmodule

// File: rtl/btb_mt.sv
module btb_mt
    import btb_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int TGT_W      = 32,
    parameter int ENTRIES    = 16,
    parameter int TAG_W      = 8,
    parameter int INST_SHIFT = 2,
    parameter int THREADS    = 4,
    localparam int TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  lk_pc,
    input  logic [TID_W-1:0] lk_tid,
    output logic             lk_hit,
    output logic [TGT_W-1:0] lk_target,
    input  logic             up_en,
    input  logic [PC_W-1:0]  up_pc,
    input  logic [TID_W-1:0] up_tid,
    input  logic [TGT_W-1:0] up_target
);

    localparam int IDX_W     = flog2(ENTRIES);
    localparam int LOG2_THR  = flog2(THREADS);
    localparam int TID_SHIFT = IDX_W - LOG2_THR;

    if (!is_pow2(ENTRIES) || ENTRIES < 2) begin : g_bad_entries
        $error("btb_mt: ENTRIES must be a power of two of at least 2");
    end
    if (!is_pow2(THREADS) || THREADS > ENTRIES) begin : g_bad_threads
        $error("btb_mt: THREADS must be a power of two not above ENTRIES");
    end

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             rd_valid;
    logic [TAG_W-1:0] rd_tag;
    logic [TID_W-1:0] rd_tid;
    logic [TGT_W-1:0] rd_tgt;

    btb_hash #(
        .PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .TID_W(TID_W),
        .INST_SHIFT(INST_SHIFT), .TID_SHIFT(TID_SHIFT)
    ) u_hash_lk (
        .pc(lk_pc), .tid(lk_tid), .idx(lk_idx), .tag(lk_tag)
    );

    btb_hash #(
        .PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .TID_W(TID_W),
        .INST_SHIFT(INST_SHIFT), .TID_SHIFT(TID_SHIFT)
    ) u_hash_up (
        .pc(up_pc), .tid(up_tid), .idx(up_idx), .tag(up_tag)
    );

    btb_store #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
        .TID_W(TID_W), .TGT_W(TGT_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .wr_en(up_en), .wr_idx(up_idx), .wr_tag(up_tag),
        .wr_tid(up_tid), .wr_tgt(up_target),
        .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
        .rd_tid(rd_tid), .rd_tgt(rd_tgt)
    );

    always_comb begin
        lk_hit    = rd_valid && (rd_tag == lk_tag) && (rd_tid == lk_tid);
        lk_target = lk_hit ? rd_tgt : '0;
    end

endmodule

// File: rtl/btb_mt_chk.sv
module btb_mt_chk #(
    parameter int PC_W  = 32,
    parameter int TGT_W = 32,
    parameter int TID_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [PC_W-1:0]  lk_pc,
    input logic [TID_W-1:0] lk_tid,
    input logic             lk_hit,
    input logic [TGT_W-1:0] lk_target,
    input logic             up_en,
    input logic [PC_W-1:0]  up_pc,
    input logic [TID_W-1:0] up_tid,
    input logic [TGT_W-1:0] up_target
);

    // R5: a miss never carries a target
    a_r5_miss_zero: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_target == '0));

    // R1 / R8: the cycle after reset sees an empty buffer
    a_r8_reset_empties: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit);

    // R6: a write is visible to a matching lookup from the next edge
    a_r6_write_visible: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(up_en) && lk_pc == $past(up_pc)
         && lk_tid == $past(up_tid))
        |-> (lk_hit && lk_target == $past(up_target)));

    // R7: with no write or reset at the last edge and steady inputs, the result holds
    a_r7_no_write_steady: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(up_en) && $stable(lk_pc) && $stable(lk_tid))
        |-> ($stable(lk_hit) && $stable(lk_target)));

endmodule

bind btb_mt btb_mt_chk #(
    .PC_W(PC_W), .TGT_W(TGT_W), .TID_W(TID_W)
) u_chk (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_tid(lk_tid),
    .lk_hit(lk_hit), .lk_target(lk_target), .up_en(up_en),
    .up_pc(up_pc), .up_tid(up_tid), .up_target(up_target)
);

// File: tb/btb_mt_tb.sv
module btb_mt_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_pc = '0;
    logic [1:0]  lk_tid = '0;
    logic        lk_hit;
    logic [31:0] lk_target;
    logic        up_en = 1'b0;
    logic [31:0] up_pc = '0;
    logic [1:0]  up_tid = '0;
    logic [31:0] up_target = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    btb_mt u_dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_tid(lk_tid),
        .lk_hit(lk_hit), .lk_target(lk_target), .up_en(up_en),
        .up_pc(up_pc), .up_tid(up_tid), .up_target(up_target)
    );

    typedef struct packed {
        logic        u_en;
        logic [31:0] u_pc;
        logic [1:0]  u_tid;
        logic [31:0] u_tgt;
        logic [31:0] l_pc;
        logic [1:0]  l_tid;
        logic        e_hit;
        logic [31:0] e_tgt;
        logic [7:0]  req;
    } vec_t;

    // Defaults: index = PC[5:2] ^ {tid,2'b00}, tag = PC[13:6]
    localparam vec_t VEC [16] = '{
        '{1'b1, 32'h100, 2'd0, 32'hAAAA0000, 32'h100, 2'd0, 1'b0, 32'h0,        8'd7 },  // R7 same-cycle write
        '{1'b0, 32'h0,   2'd0, 32'h0,        32'h100, 2'd0, 1'b1, 32'hAAAA0000, 8'd6 },  // R6 visible
        '{1'b0, 32'h0,   2'd0, 32'h0,        32'h100, 2'd1, 1'b0, 32'h0,        8'd2 },  // R2 tid 1 -> slot 4
        '{1'b1, 32'h100, 2'd1, 32'hBBBB0000, 32'h100, 2'd0, 1'b1, 32'hAAAA0000, 8'd2 },  // R2 slot 0 untouched
        '{1'b0, 32'h0,   2'd0, 32'h0,        32'h100, 2'd1, 1'b1, 32'hBBBB0000, 8'd2 },  // R2
        '{1'b0, 32'h0,   2'd0, 32'h0,        32'h103, 2'd0, 1'b1, 32'hAAAA0000, 8'd9 },  // R9 low bits
        '{1'b0, 32'h0,   2'd0, 32'h0,        32'h4100,2'd0, 1'b1, 32'hAAAA0000, 8'd9 },  // R9 bits above tag
        '{1'b0, 32'h0,   2'd0, 32'h0,        32'h140, 2'd0, 1'b0, 32'h0,        8'd3 },  // R3 tag 5 vs 4
        '{1'b0, 32'h0,   2'd0, 32'h0,        32'h110, 2'd1, 1'b0, 32'h0,        8'd4 },  // R4 slot 0 tag ok, tid differs
        '{1'b1, 32'h140, 2'd0, 32'hCCCC0000, 32'h140, 2'd0, 1'b0, 32'h0,        8'd7 },  // R7
        '{1'b0, 32'h0,   2'd0, 32'h0,        32'h140, 2'd0, 1'b1, 32'hCCCC0000, 8'd6 },  // R6 overwrite
        '{1'b0, 32'h0,   2'd0, 32'h0,        32'h100, 2'd0, 1'b0, 32'h0,        8'd6 },  // R6 evicted
        '{1'b1, 32'h3C,  2'd3, 32'h0,        32'h3C,  2'd3, 1'b0, 32'h0,        8'd7 },  // R7 slot 3
        '{1'b0, 32'h0,   2'd0, 32'h0,        32'h3C,  2'd3, 1'b1, 32'h0,        8'd10},  // R10 zero target hit
        '{1'b0, 32'h0,   2'd0, 32'h0,        32'h0C,  2'd0, 1'b0, 32'h0,        8'd4 },  // R4 slot 3 tid 3 vs 0
        '{1'b0, 32'h0,   2'd0, 32'h0,        32'h100, 2'd1, 1'b1, 32'hBBBB0000, 8'd2 }   // R2 slot 4 kept
    };

    task automatic check(input logic e_hit, input logic [31:0] e_tgt, input string req);
        checks++;
        if (lk_hit !== e_hit || lk_target !== e_tgt) begin
            errors++;
            $display("FAIL %s: hit=%0b target=%h expected hit=%0b target=%h",
                     req, lk_hit, lk_target, e_hit, e_tgt);
        end
    endtask

    task automatic look(input logic [31:0] pc, input logic [1:0] tid,
                        input logic e_hit, input logic [31:0] e_tgt, input string req);
        @(posedge clk);
        #1;
        lk_pc  = pc;
        lk_tid = tid;
        up_en  = 1'b0;
        @(negedge clk);
        check(e_hit, e_tgt, req);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: empty after reset
        @(negedge clk);
        check(1'b0, 32'h0, "R1");
        look(32'h100, 2'd1, 1'b0, 32'h0, "R1");

        for (int i = 0; i < 16; i++) begin
            @(posedge clk);
            #1;
            up_en     = VEC[i].u_en;
            up_pc     = VEC[i].u_pc;
            up_tid    = VEC[i].u_tid;
            up_target = VEC[i].u_tgt;
            lk_pc     = VEC[i].l_pc;
            lk_tid    = VEC[i].l_tid;
            @(negedge clk);
            check(VEC[i].e_hit, VEC[i].e_tgt, $sformatf("R%0d row %0d", VEC[i].req, i));
        end

        // R8: reset with a simultaneous write; the write is dropped
        @(posedge clk);
        #1;
        rst       = 1'b1;
        up_en     = 1'b1;
        up_pc     = 32'h200;
        up_tid    = 2'd2;
        up_target = 32'hDDDD0000;
        @(posedge clk);
        #1;
        rst   = 1'b0;
        up_en = 1'b0;
        look(32'h200, 2'd2, 1'b0, 32'h0, "R8 write during reset");
        look(32'h140, 2'd0, 1'b0, 32'h0, "R8 slot 0 cleared");
        look(32'h100, 2'd1, 1'b0, 32'h0, "R8 slot 4 cleared");
        look(32'h3C,  2'd3, 1'b0, 32'h0, "R8 slot 3 cleared");

        // R6: writing works again after reset
        @(posedge clk);
        #1;
        up_en     = 1'b1;
        up_pc     = 32'h200;
        up_tid    = 2'd2;
        up_target = 32'hEEEE0004;
        look(32'h200, 2'd2, 1'b1, 32'hEEEE0004, "R6 after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule